// File: doc/BRIEF.md
# Atomic Lock Prefix Control Unit

This unit sits between instruction decode and the memory pipeline. It watches a stream of decoded elements, each of which is either the one-byte lock prefix or a simplified instruction descriptor. The descriptor carries a 5-bit instruction class, a memory-operand flag and the number of memory accesses the instruction needs. From these the unit decides whether the instruction may run as an atomic read-modify-write. If it may, the unit holds a bus-lock output across every access of that instruction. If it may not, the unit raises an undefined-opcode fault or a lock-intercept fault.

Exchange is special: it locks even when no prefix is present. A control bit can also turn a required external bus lock into an intercept fault, so that software emulates the instruction and no atomic transaction reaches the bus. Accesses are reported back by the memory side through start and done strobes. Misaligned operands that need several accesses keep the lock for all of them.

Top module: `lock_prefix_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `bus_lock`, `mem_req`, `ud_fault`, `icpt_fault` and `insn_done` are 0 and `desc_ready` is 1.
- R2: An accepted element whose `desc_byte` is 8'hF0 is a prefix. It produces no output activity and arms only the next accepted non-prefix element. That element disarms the prefix whatever its outcome, and repeated prefixes still arm just one instruction.
- R3: For a prefixed instruction whose class code is in 0..16 and whose `desc_mem` is 1, `bus_lock` is 0 before the first `acc_start`. It is 1 in the cycle `acc_start` is first high. It is 0 in the cycle after the final `acc_done`.
- R4: A prefixed instruction whose class code is outside 0..16 gives a one-cycle `ud_fault` in the cycle after acceptance. It issues no `mem_req` and no `bus_lock`.
- R5: A prefixed instruction with `desc_mem` = 0 gives `ud_fault`, even when its class code is in 0..16.
- R6: Class code 16 (exchange) with `desc_mem` = 1 runs locked without a prefix. Without a memory operand it runs unlocked and without a fault.
- R7: When an instruction would need the lock, and `ext_lock_req` and `lock_chk` are both 1 at acceptance, a one-cycle `icpt_fault` is given instead, with no `mem_req` and no `bus_lock`. An undefined-opcode case gives `ud_fault` only, which takes priority.
- R8: With `ext_lock_req` = 1 and `lock_chk` = 0, a lock-needing instruction runs locked normally.
- R9: An unprefixed memory instruction other than class 16 performs its accesses with `bus_lock` 0, even when `ext_lock_req` and `lock_chk` are 1.
- R10: A locked instruction keeps `bus_lock` at 1 between all of its `desc_nacc` accesses, including the gaps between them. A `desc_nacc` of 0 counts as one access.
- R11: `insn_done` is a one-cycle pulse. It comes in the cycle after the final `acc_done`, or in the cycle after acceptance for a non-memory instruction that does not fault. A faulting instruction never gives it. At most one of `ud_fault`, `icpt_fault`, `insn_done` is high at a time.
- R12: `mem_req` is 1 from the cycle after acceptance of a non-faulting memory instruction through the cycle of its final `acc_done`. While `mem_req` is 1, `desc_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | Stream element present |
| desc_ready | output | 1 | Unit can accept an element |
| desc_byte | input | 8 | First byte of the element; 8'hF0 marks the lock prefix |
| desc_cls | input | 5 | Instruction class code (0..16 lockable, 16 exchange) |
| desc_mem | input | 1 | Instruction has a memory operand |
| desc_nacc | input | 3 | Number of memory accesses (0 treated as 1) |
| ext_lock_req | input | 1 | An external bus lock is required for this access |
| lock_chk | input | 1 | Control bit: intercept instead of external bus lock |
| mem_req | output | 1 | Memory accesses of the current instruction may proceed |
| acc_start | input | 1 | A memory access starts this cycle |
| acc_done | input | 1 | A memory access completes this cycle |
| bus_lock | output | 1 | Bus lock held |
| ud_fault | output | 1 | Undefined-opcode fault pulse |
| icpt_fault | output | 1 | Lock-intercept fault pulse |
| insn_done | output | 1 | Instruction-complete pulse |

## Verification
The main function is exercised with prefixed lockable classes, prefixed non-lockable classes, prefixed register forms, unprefixed exchange in memory and register form, and unprefixed ordinary memory instructions. Each pattern separates a different branch of the legality decision: opcode check, operand-form check, and implicit locking. The intercept pair of inputs is swept across locked, unlocked and faulting instructions. This shows that the control bit acts only when a lock would be taken, and that an undefined opcode outranks it. Access counts of 0, 1, 2 and 4 expose lock timing at the first start, in the gaps between accesses and after the last done.

// File: rtl/lkp_pkg.sv
// Package: shared class encoding and constants for the lock prefix unit.
// Assumes class codes 0..16 are the lockable read-modify-write classes and
// code 16 is exchange; every other code is an ordinary instruction.
package lkp_pkg;

    localparam int CLS_W = 5;

    typedef enum logic [CLS_W-1:0] {
        CLS_ADD     = 5'd0,
        CLS_ADC     = 5'd1,
        CLS_AND     = 5'd2,
        CLS_BTC     = 5'd3,
        CLS_BTR     = 5'd4,
        CLS_BTS     = 5'd5,
        CLS_CMPXCHG = 5'd6,
        CLS_DEC     = 5'd7,
        CLS_INC     = 5'd8,
        CLS_NEG     = 5'd9,
        CLS_NOT     = 5'd10,
        CLS_OR      = 5'd11,
        CLS_SBB     = 5'd12,
        CLS_SUB     = 5'd13,
        CLS_XOR     = 5'd14,
        CLS_XADD    = 5'd15,
        CLS_XCHG    = 5'd16,
        CLS_MOV     = 5'd17,
        CLS_CMP     = 5'd18,
        CLS_OTHER   = 5'd31
    } lkp_cls_e;

    // Lockable classes occupy the contiguous range ending at exchange.
    function automatic logic cls_lockable(lkp_cls_e c);
        return (c <= CLS_XCHG);
    endfunction

endpackage

// File: rtl/lkp_prefix_track.sv
// Prefix tracker: recognises the lock prefix element in the stream and
// remembers it for exactly one following instruction.
// Assumes an element is consumed only on the cycle 'take' is high.
module lkp_prefix_track #(
    parameter int          BYTE_W   = 8,
    parameter logic [7:0]  PFX_CODE = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BYTE_W-1:0] elem_byte,
    output logic              is_pfx,
    output logic              armed
);

    // Identify the prefix element by its byte value.
    assign is_pfx = (elem_byte == PFX_CODE[BYTE_W-1:0]);

    // Arm on a prefix, disarm on any consumed instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (take)
            armed <= is_pfx;
    end

endmodule

// File: rtl/lkp_legality.sv
// Legality check: decides, for one instruction descriptor, whether it
// faults, whether it needs the bus lock, and whether the intercept applies.
// Purely combinational; inputs are sampled by the sequencer on acceptance.
module lkp_legality
    import lkp_pkg::*;
#(
    parameter bit IMPLICIT_XCHG = 1'b1
) (
    input  logic             armed,
    input  logic [CLS_W-1:0] cls,
    input  logic             has_mem,
    input  logic             ext_req,
    input  logic             chk,
    output logic             bad_op,
    output logic             need_lock,
    output logic             intercept
);

    lkp_cls_e c;
    logic     legal_form;
    logic     implicit_lk;

    // Interpret the raw class field.
    assign c = lkp_cls_e'(cls);

    // A prefixed form is legal only for lockable classes with a memory operand.
    assign legal_form = cls_lockable(c) && has_mem;

    // Select whether exchange locks without the prefix.
    generate
        if (IMPLICIT_XCHG) begin : g_impl
            assign implicit_lk = has_mem && (c == CLS_XCHG);
        end else begin : g_no_impl
            assign implicit_lk = 1'b0;
        end
    endgenerate

    // Combine the decisions; undefined opcode outranks the intercept.
    always_comb begin
        bad_op    = armed && !legal_form;
        need_lock = !bad_op && ((armed && legal_form) || implicit_lk);
        intercept = need_lock && ext_req && chk;
    end

endmodule

// File: rtl/lkp_exec_seq.sv
// Execution sequencer: launches the accepted instruction, counts its memory
// accesses, holds the bus lock from the first access start until after the
// final access done, and produces the fault and completion pulses.
// Assumes the memory side strobes acc_start/acc_done only while mem_req is high.
module lkp_exec_seq #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_take,
    input  logic             bad_op,
    input  logic             need_lock,
    input  logic             intercept,
    input  logic             has_mem,
    input  logic [CNT_W-1:0] nacc,
    input  logic             acc_start,
    input  logic             acc_done,
    output logic             busy,
    output logic             bus_lock,
    output logic             ud_pulse,
    output logic             icpt_pulse,
    output logic             done_pulse
);

    logic             busy_q;
    logic             lock_q;
    logic             lk_insn_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;
    logic             ud_q;
    logic             icpt_q;
    logic             done_q;
    logic             launch;
    logic             final_done;

    // Start a memory instruction only when it neither faults nor intercepts.
    assign launch     = insn_take && !bad_op && !intercept;
    assign final_done = busy_q && acc_done && (cnt_q == last_q);

    // Sequencing state, lock holding and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            lock_q    <= 1'b0;
            lk_insn_q <= 1'b0;
            cnt_q     <= '0;
            last_q    <= '0;
            ud_q      <= 1'b0;
            icpt_q    <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            ud_q   <= insn_take && bad_op;
            icpt_q <= insn_take && !bad_op && intercept;
            done_q <= 1'b0;
            if (!busy_q) begin
                if (launch) begin
                    if (has_mem) begin
                        busy_q    <= 1'b1;
                        lk_insn_q <= need_lock;
                        cnt_q     <= '0;
                        last_q    <= (nacc == '0) ? '0 : nacc - 1'b1;
                    end else begin
                        done_q <= 1'b1;
                    end
                end
            end else begin
                if (acc_start && lk_insn_q)
                    lock_q <= 1'b1;
                if (acc_done) begin
                    if (final_done) begin
                        busy_q    <= 1'b0;
                        lock_q    <= 1'b0;
                        lk_insn_q <= 1'b0;
                        done_q    <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    // Lock rises combinationally with the first start, then is held by lock_q.
    assign bus_lock   = lock_q || (busy_q && lk_insn_q && acc_start);
    assign busy       = busy_q;
    assign ud_pulse   = ud_q;
    assign icpt_pulse = icpt_q;
    assign done_pulse = done_q;

endmodule

// File: rtl/lock_prefix_ctrl.sv
// Top of the atomic lock prefix control unit. Accepts one stream element per
// cycle while idle, tracks the prefix, checks legality and sequences locked
// or unlocked memory accesses. Assumes the descriptor fields and the
// ext_lock_req/lock_chk inputs are valid in the cycle the element is taken.
module lock_prefix_ctrl
    import lkp_pkg::*;
#(
    parameter int         BYTE_W        = 8,
    parameter int         NACC_W        = 3,
    parameter logic [7:0] PFX_CODE      = 8'hF0,
    parameter bit         IMPLICIT_XCHG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [BYTE_W-1:0] desc_byte,
    input  logic [CLS_W-1:0]  desc_cls,
    input  logic              desc_mem,
    input  logic [NACC_W-1:0] desc_nacc,
    input  logic              ext_lock_req,
    input  logic              lock_chk,
    output logic              mem_req,
    input  logic              acc_start,
    input  logic              acc_done,
    output logic              bus_lock,
    output logic              ud_fault,
    output logic              icpt_fault,
    output logic              insn_done
);

    logic take;
    logic is_pfx;
    logic armed;
    logic insn_take;
    logic bad_op;
    logic need_lock;
    logic intercept;
    logic busy;

    // Accept elements only while no instruction is executing.
    assign desc_ready = !busy;
    assign take       = desc_valid && desc_ready;
    assign insn_take  = take && !is_pfx;

    lkp_prefix_track #(
        .BYTE_W   (BYTE_W),
        .PFX_CODE (PFX_CODE)
    ) u_pfx (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .elem_byte (desc_byte),
        .is_pfx    (is_pfx),
        .armed     (armed)
    );

    lkp_legality #(
        .IMPLICIT_XCHG (IMPLICIT_XCHG)
    ) u_legal (
        .armed     (armed),
        .cls       (desc_cls),
        .has_mem   (desc_mem),
        .ext_req   (ext_lock_req),
        .chk       (lock_chk),
        .bad_op    (bad_op),
        .need_lock (need_lock),
        .intercept (intercept)
    );

    lkp_exec_seq #(
        .CNT_W (NACC_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_take  (insn_take),
        .bad_op     (bad_op),
        .need_lock  (need_lock),
        .intercept  (intercept),
        .has_mem    (desc_mem),
        .nacc       (desc_nacc),
        .acc_start  (acc_start),
        .acc_done   (acc_done),
        .busy       (busy),
        .bus_lock   (bus_lock),
        .ud_pulse   (ud_fault),
        .icpt_pulse (icpt_fault),
        .done_pulse (insn_done)
    );

    assign mem_req = busy;

endmodule

// File: rtl/lkp_checker.sv
// Checker: temporal properties of the lock prefix unit, observed at its ports.
module lkp_checker (
    input logic clk,
    input logic rst_n,
    input logic desc_ready,
    input logic mem_req,
    input logic bus_lock,
    input logic ud_fault,
    input logic icpt_fault,
    input logic insn_done
);

    // R4: an undefined-opcode fault never coincides with a request or lock.
    a_r4_ud_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ud_fault |-> (!mem_req && !bus_lock));

    // R7: an intercept fault never coincides with a request or lock.
    a_r7_icpt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        icpt_fault |-> (!mem_req && !bus_lock));

    // R3: the lock is only held while accesses are permitted.
    a_r3_lock_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_lock |-> mem_req);

    // R10: once held, the lock stays while the instruction is still running.
    a_r10_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && mem_req) |=> (bus_lock || !mem_req));

    // R11: result pulses are mutually exclusive.
    a_r11_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ud_fault, icpt_fault, insn_done}));

    // R12: no new element is accepted while accesses run.
    a_r12_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !desc_ready);

    // R11: completion is never reported while accesses are still permitted.
    a_r11_done_after: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done |-> !mem_req);

endmodule

bind lock_prefix_ctrl lkp_checker u_lkp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_ready (desc_ready),
    .mem_req    (mem_req),
    .bus_lock   (bus_lock),
    .ud_fault   (ud_fault),
    .icpt_fault (icpt_fault),
    .insn_done  (insn_done)
);

// File: tb/tb_lock_prefix_ctrl.sv
`timescale 1ns/1ps
module tb_lock_prefix_ctrl;

    localparam int K_DONE = 0;
    localparam int K_UD   = 1;
    localparam int K_ICPT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       desc_valid = 1'b0;
    logic       desc_ready;
    logic [7:0] desc_byte = 8'h00;
    logic [4:0] desc_cls = 5'd0;
    logic       desc_mem = 1'b0;
    logic [2:0] desc_nacc = 3'd0;
    logic       ext_lock_req = 1'b0;
    logic       lock_chk = 1'b0;
    logic       mem_req;
    logic       acc_start = 1'b0;
    logic       acc_done = 1'b0;
    logic       bus_lock;
    logic       ud_fault;
    logic       icpt_fault;
    logic       insn_done;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    finished = 1'b0;
    int    exp_kind_q[$];
    string exp_tag_q[$];

    always #4 clk = ~clk;

    lock_prefix_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .desc_valid   (desc_valid),
        .desc_ready   (desc_ready),
        .desc_byte    (desc_byte),
        .desc_cls     (desc_cls),
        .desc_mem     (desc_mem),
        .desc_nacc    (desc_nacc),
        .ext_lock_req (ext_lock_req),
        .lock_chk     (lock_chk),
        .mem_req      (mem_req),
        .acc_start    (acc_start),
        .acc_done     (acc_done),
        .bus_lock     (bus_lock),
        .ud_fault     (ud_fault),
        .icpt_fault   (icpt_fault),
        .insn_done    (insn_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Monitor: pop an expected result for every result pulse seen.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && (ud_fault || icpt_fault || insn_done)) begin
                int kind;
                string tag;
                kind = insn_done ? K_DONE : (ud_fault ? K_UD : K_ICPT);
                if (ud_fault + icpt_fault + insn_done > 1)
                    check(1'b0, "R11", "several result pulses", 2, 1);
                if (exp_kind_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected result kind", kind, -1);
                end else begin
                    int ek;
                    ek  = exp_kind_q.pop_front();
                    tag = exp_tag_q.pop_front();
                    check(kind == ek, tag, "result kind", kind, ek);
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_prefix();
        @(negedge clk);
        desc_valid = 1'b1;
        desc_byte  = 8'hF0;
        desc_cls   = 5'd31;
        desc_mem   = 1'b0;
        @(negedge clk);
        desc_valid = 1'b0;
        desc_byte  = 8'h00;
        #1;
        // R2: the prefix alone produces no activity
        check(!mem_req && !bus_lock && desc_ready, "R2", "prefix activity",
              {mem_req, bus_lock}, 0);
    endtask

    // Driver: run one instruction, push the expected result and service accesses.
    task automatic run_insn(input bit pfx, input int cls, input bit mem,
                            input int nacc, input bit ext, input bit chk,
                            input int exp_kind, input bit exp_lock,
                            input string tag);
        int n;
        if (pfx) send_prefix();
        @(negedge clk);
        desc_valid   = 1'b1;
        desc_byte    = 8'h01;
        desc_cls     = cls[4:0];
        desc_mem     = mem;
        desc_nacc    = nacc[2:0];
        ext_lock_req = ext;
        lock_chk     = chk;
        exp_kind_q.push_back(exp_kind);
        exp_tag_q.push_back(tag);
        @(negedge clk);
        desc_valid   = 1'b0;
        ext_lock_req = 1'b0;
        lock_chk     = 1'b0;
        #1;
        if (exp_kind != K_DONE || !mem) begin
            check(!mem_req && !bus_lock, tag, "no request after accept",
                  {mem_req, bus_lock}, 0);
        end else begin
            check(mem_req && !desc_ready, "R12", "request after accept",
                  {mem_req, desc_ready}, 2);
            check(!bus_lock, "R3", "lock before first start", bus_lock, 0);
            n = (nacc == 0) ? 1 : nacc;
            for (int k = 0; k < n; k++) begin
                @(negedge clk);
                acc_start = 1'b1;
                #1;
                check(bus_lock == exp_lock, tag, "lock at start", bus_lock, exp_lock);
                @(negedge clk);
                acc_start = 1'b0;
                #1;
                check(bus_lock == exp_lock && mem_req, "R10", "lock before done",
                      bus_lock, exp_lock);
                acc_done = 1'b1;
                @(negedge clk);
                acc_done = 1'b0;
                #1;
                if (k == n - 1) begin
                    check(!bus_lock, "R3", "lock after final done", bus_lock, 0);
                    check(!mem_req && desc_ready, "R12", "request after final done",
                          mem_req, 0);
                end else begin
                    check(bus_lock == exp_lock && mem_req, "R10", "lock between accesses",
                          bus_lock, exp_lock);
                end
            end
        end
        idle(2);
        check(exp_kind_q.size() == 0, tag, "result still pending",
              exp_kind_q.size(), 0);
    endtask

    // Watchdog.
    initial begin
        #1000000;
        check(1'b0, "R1", "watchdog expired", 1, 0);
        finish_up();
    end

    initial begin
        idle(3);
        #1;
        // R1: reset state
        check(!bus_lock && !mem_req && !ud_fault && !icpt_fault && !insn_done && desc_ready,
              "R1", "outputs in reset", {bus_lock, mem_req, ud_fault, icpt_fault, insn_done}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!bus_lock && !mem_req && !insn_done && desc_ready, "R1", "after reset",
              {bus_lock, mem_req, insn_done}, 0);

        run_insn(1, 0,  1, 2, 0, 0, K_DONE, 1, "R3");   // prefixed add, memory
        run_insn(0, 0,  1, 2, 0, 0, K_DONE, 0, "R2");   // prefix consumed already
        run_insn(0, 16, 1, 2, 0, 0, K_DONE, 1, "R6");   // implicit exchange lock
        run_insn(0, 16, 0, 0, 0, 0, K_DONE, 0, "R6");   // register exchange
        run_insn(1, 17, 1, 2, 0, 0, K_UD,   0, "R4");   // non-lockable class
        run_insn(0, 13, 1, 2, 0, 0, K_DONE, 0, "R2");   // fault also disarms
        run_insn(1, 8,  0, 0, 0, 0, K_UD,   0, "R5");   // register form
        run_insn(1, 5,  1, 2, 1, 1, K_ICPT, 0, "R7");   // intercept
        run_insn(1, 5,  1, 2, 1, 0, K_DONE, 1, "R8");   // external lock allowed
        run_insn(1, 6,  1, 4, 0, 0, K_DONE, 1, "R10");  // misaligned, four accesses
        run_insn(0, 16, 1, 2, 1, 1, K_ICPT, 0, "R7");   // implicit lock intercepted
        run_insn(1, 31, 0, 0, 1, 1, K_UD,   0, "R7");   // undefined outranks intercept
        send_prefix();
        run_insn(1, 14, 1, 2, 0, 0, K_DONE, 1, "R2");   // double prefix
        run_insn(0, 14, 1, 1, 0, 0, K_DONE, 0, "R2");   // only one instruction armed
        run_insn(0, 0,  1, 2, 1, 1, K_DONE, 0, "R9");   // no lock, no intercept
        run_insn(1, 15, 1, 0, 0, 0, K_DONE, 1, "R10");  // zero count = one access
        run_insn(0, 18, 0, 0, 0, 0, K_DONE, 0, "R11");  // plain register op
        idle(3);
        finish_up();
    end

endmodule